// File: doc/BRIEF.md
# Precise interrupt retirement controller

This block decides when a processor core accepts its single maskable external interrupt and which in-flight instruction the interrupt attaches to. It owns a small circular history buffer of in-flight instructions in program order. Each slot holds a valid bit, a done bit, a fault bit, a three-bit instruction class and the program counter. The pipeline allocates a slot at issue and later reports completion by slot tag, with or without a fault. Outside interrupt handling, the oldest slot retires once it is done without a fault. The oldest slot that is done with a fault raises an instruction-caused interrupt.

An external request is seen only while the global enable is set. When one is seen, the block stalls issue and drains the buffer one slot per clock. During the drain, only done, fault-free instructions of the allowed classes may retire. If the drain stops at a slot that may not retire, that slot and every younger slot are flushed, and the resume address is the PC of the first flushed slot. If the buffer empties, the resume address is the PC after the last retired instruction. Instruction faults are handled first. Every interrupt the block takes clears the global enable. A return-from-interrupt retirement restores the enable from the value saved when the last interrupt was taken.

Top module: `irq_ret_ctrl`

## Requirements
- R1: After reset the buffer is empty (`buf_full_o`=0), the global enable `msr_ee_o` is 1, and `issue_stall_o`, `retire_o` and `take_o` are 0.
- R2: Outside a drain, the oldest slot retires once it is done without a fault, whatever its class. `retire_o` pulses for one cycle with `retire_pc_o` set to its PC. At most one instruction retires per clock, and retirement follows allocation order.
- R3: An external request seen while `msr_ee_o`=1 and no drain is active raises `issue_stall_o` from the next cycle. The stall holds until the interrupt is taken, and allocations presented during the stall are dropped.
- R4: During a drain the oldest slot may retire only if it is done without a fault and its class is one of 2 (register move), 3 (return from interrupt), 4 (memory reference) or 5 (storage/cache control). A slot of an allowed class that is not yet done is waited for while the stall holds.
- R5: During a drain, if the oldest slot has class 0 or 1, the external interrupt is taken at once. `take_o` and `flush_o` pulse together with `take_exc_o`=0 and `epc_o` set to that slot's PC, and that slot and every younger slot are removed.
- R6: During a drain, if the buffer becomes empty, the external interrupt is taken with `epc_o` equal to the PC of the last retired instruction plus INSN_BYTES.
- R7: Every take clears `msr_ee_o` in the cycle that `take_o` pulses. `take_o` is a single-cycle pulse.
- R8: A slot at the head that is done with a fault is taken as an instruction interrupt (`take_exc_o`=1, `epc_o` = its PC, buffer flushed). This happens even if an external request was seen in the same or an earlier cycle, so the older fault wins.
- R9: When several slots hold faults, only the oldest one is taken. A fault in a younger slot never produces its own take.
- R10: Retiring a class-3 instruction sets `msr_ee_o` to the enable value saved at the last take. An external request present in that retirement cycle is seen only from the following cycle.
- R11: While `msr_ee_o`=0 an external request has no effect: no stall and no take.
- R12: While the buffer is full (`buf_full_o`=1), allocations are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Allocate a slot for an issued instruction |
| alloc_pc_i | input | PC_W | PC of the issued instruction |
| alloc_cls_i | input | 3 | Instruction class code |
| alloc_tag_o | output | log2(DEPTH) | Tag the next allocation will receive |
| buf_full_o | output | 1 | All slots occupied |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_tag_i | input | log2(DEPTH) | Tag of the completing slot |
| cmpl_exc_i | input | 1 | Completion raised a fault |
| ext_irq_req_i | input | 1 | Level external interrupt request |
| issue_stall_o | output | 1 | Drain in progress, hold issue |
| retire_o | output | 1 | One instruction retired |
| retire_pc_o | output | PC_W | PC of the retired instruction |
| take_o | output | 1 | Interrupt taken |
| take_exc_o | output | 1 | 1: instruction fault, 0: external |
| epc_o | output | PC_W | Resume or faulting PC |
| flush_o | output | 1 | Discard all in-flight slots |
| msr_ee_o | output | 1 | Global external interrupt enable |

## Verification
The bench builds the block with DEPTH=4, PC_W=32 and INSN_BYTES=4. With only four slots, the full-buffer boundary is reached after four allocations, and the head and tail pointers wrap several times across the sequence. Within a few cycles, this gives drains that end at an empty buffer, drains that stop at a disallowed class, and drains that wait on an unfinished memory reference. The 32-bit PC and 4-byte step let the next-sequential resume address be checked as exact values.

// File: rtl/irq_ret_pkg.sv
package irq_ret_pkg;

    localparam int CLS_W = 3;

    // instruction class codes
    localparam logic [CLS_W-1:0] CLS_ALU    = 3'd0;
    localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd1;
    localparam logic [CLS_W-1:0] CLS_MOVE   = 3'd2;
    localparam logic [CLS_W-1:0] CLS_RFI    = 3'd3;
    localparam logic [CLS_W-1:0] CLS_MEM    = 3'd4;
    localparam logic [CLS_W-1:0] CLS_CACHE  = 3'd5;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } irq_st_e;

    // classes allowed to retire while an external interrupt drains the buffer
    function automatic logic cls_may_drain(input logic [CLS_W-1:0] cls);
        return (cls == CLS_MOVE) || (cls == CLS_RFI) ||
               (cls == CLS_MEM)  || (cls == CLS_CACHE);
    endfunction

endpackage

// File: rtl/irq_hist_buf.sv
module irq_hist_buf #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 32,
    parameter int CLS_W = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [PC_W-1:0]  push_pc_i,
    input  logic [CLS_W-1:0] push_cls_i,
    input  logic             pop_i,
    input  logic             clr_i,
    input  logic             cmpl_i,
    input  logic [IDX_W-1:0] cmpl_tag_i,
    input  logic             cmpl_exc_i,
    output logic [IDX_W-1:0] tail_o,
    output logic             full_o,
    output logic             head_vld_o,
    output logic             head_done_o,
    output logic             head_exc_o,
    output logic [CLS_W-1:0] head_cls_o,
    output logic [PC_W-1:0]  head_pc_o
);

    typedef struct packed {
        logic             vld;
        logic             done;
        logic             exc;
        logic [CLS_W-1:0] cls;
        logic [PC_W-1:0]  pc;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]  hd;
        logic [IDX_W-1:0]  tl;
        logic [CNT_W-1:0]  cnt;
    } hb_t;

    hb_t hb_d, hb_q;
    logic do_push, do_pop;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
    endfunction

    always_comb begin
        hb_d    = hb_q;
        do_push = push_i && (hb_q.cnt != CNT_W'(DEPTH)) && !clr_i;
        do_pop  = pop_i && hb_q.slot[hb_q.hd].vld;

        for (int i = 0; i < DEPTH; i++) begin
            if (cmpl_i && (cmpl_tag_i == IDX_W'(i)) && hb_q.slot[i].vld) begin
                hb_d.slot[i].done = 1'b1;
                hb_d.slot[i].exc  = cmpl_exc_i;
            end
        end

        if (do_pop) begin
            hb_d.slot[hb_q.hd].vld = 1'b0;
            hb_d.hd                = step(hb_q.hd);
        end

        if (do_push) begin
            hb_d.slot[hb_q.tl].vld  = 1'b1;
            hb_d.slot[hb_q.tl].done = 1'b0;
            hb_d.slot[hb_q.tl].exc  = 1'b0;
            hb_d.slot[hb_q.tl].cls  = push_cls_i;
            hb_d.slot[hb_q.tl].pc   = push_pc_i;
            hb_d.tl                 = step(hb_q.tl);
        end

        hb_d.cnt = hb_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);

        if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                hb_d.slot[i].vld = 1'b0;
            end
            hb_d.hd  = '0;
            hb_d.tl  = '0;
            hb_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= '0;
        end else begin
            hb_q <= hb_d;
        end
    end

    assign tail_o      = hb_q.tl;
    assign full_o      = (hb_q.cnt == CNT_W'(DEPTH));
    assign head_vld_o  = hb_q.slot[hb_q.hd].vld;
    assign head_done_o = hb_q.slot[hb_q.hd].done;
    assign head_exc_o  = hb_q.slot[hb_q.hd].exc;
    assign head_cls_o  = hb_q.slot[hb_q.hd].cls;
    assign head_pc_o   = hb_q.slot[hb_q.hd].pc;

endmodule

// File: rtl/irq_head_qual.sv
module irq_head_qual
    import irq_ret_pkg::*;
(
    input  logic             vld_i,
    input  logic             done_i,
    input  logic             exc_i,
    input  logic [CLS_W-1:0] cls_i,
    output logic             fault_o,
    output logic             ok_o,
    output logic             drain_ok_o,
    output logic             rfi_o
);

    always_comb begin
        fault_o    = vld_i && done_i && exc_i;
        ok_o       = vld_i && done_i && !exc_i;
        drain_ok_o = cls_may_drain(cls_i);
        rfi_o      = (cls_i == CLS_RFI);
    end

endmodule

// File: rtl/irq_ret_ctrl.sv
module irq_ret_ctrl
    import irq_ret_pkg::*;
#(
    parameter int              DEPTH      = 4,
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = '0,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid_i,
    input  logic [PC_W-1:0]  alloc_pc_i,
    input  logic [2:0]       alloc_cls_i,
    output logic [IDX_W-1:0] alloc_tag_o,
    output logic             buf_full_o,
    input  logic             cmpl_valid_i,
    input  logic [IDX_W-1:0] cmpl_tag_i,
    input  logic             cmpl_exc_i,
    input  logic             ext_irq_req_i,
    output logic             issue_stall_o,
    output logic             retire_o,
    output logic [PC_W-1:0]  retire_pc_o,
    output logic             take_o,
    output logic             take_exc_o,
    output logic [PC_W-1:0]  epc_o,
    output logic             flush_o,
    output logic             msr_ee_o
);

    typedef struct packed {
        irq_st_e         st;
        logic            ee;
        logic            saved_ee;
        logic [PC_W-1:0] nxt_pc;
        logic            retire;
        logic [PC_W-1:0] retire_pc;
        logic            take;
        logic            take_exc;
        logic [PC_W-1:0] epc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             hd_vld, hd_done, hd_exc;
    logic [CLS_W-1:0] hd_cls;
    logic [PC_W-1:0]  hd_pc;
    logic             hd_fault, hd_ok, hd_drain_ok, hd_rfi;
    logic             buf_pop, buf_clr, buf_push;

    assign buf_push = alloc_valid_i && (ctl_q.st == ST_RUN);

    irq_hist_buf #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .CLS_W (CLS_W)
    ) u_hbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (buf_push),
        .push_pc_i   (alloc_pc_i),
        .push_cls_i  (alloc_cls_i),
        .pop_i       (buf_pop),
        .clr_i       (buf_clr),
        .cmpl_i      (cmpl_valid_i),
        .cmpl_tag_i  (cmpl_tag_i),
        .cmpl_exc_i  (cmpl_exc_i),
        .tail_o      (alloc_tag_o),
        .full_o      (buf_full_o),
        .head_vld_o  (hd_vld),
        .head_done_o (hd_done),
        .head_exc_o  (hd_exc),
        .head_cls_o  (hd_cls),
        .head_pc_o   (hd_pc)
    );

    irq_head_qual u_qual (
        .vld_i      (hd_vld),
        .done_i     (hd_done),
        .exc_i      (hd_exc),
        .cls_i      (hd_cls),
        .fault_o    (hd_fault),
        .ok_o       (hd_ok),
        .drain_ok_o (hd_drain_ok),
        .rfi_o      (hd_rfi)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.retire   = 1'b0;
        ctl_d.take     = 1'b0;
        ctl_d.take_exc = 1'b0;
        buf_pop        = 1'b0;
        buf_clr        = 1'b0;

        unique case (ctl_q.st)
            ST_RUN: begin
                if (hd_fault) begin
                    ctl_d.take     = 1'b1;
                    ctl_d.take_exc = 1'b1;
                    ctl_d.epc      = hd_pc;
                end else if (ext_irq_req_i && ctl_q.ee) begin
                    ctl_d.st = ST_DRAIN;
                end else if (hd_ok) begin
                    ctl_d.retire = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (hd_fault) begin
                    ctl_d.take     = 1'b1;
                    ctl_d.take_exc = 1'b1;
                    ctl_d.epc      = hd_pc;
                end else if (!hd_vld) begin
                    ctl_d.take = 1'b1;
                    ctl_d.epc  = ctl_q.nxt_pc;
                end else if (!hd_drain_ok) begin
                    ctl_d.take = 1'b1;
                    ctl_d.epc  = hd_pc;
                end else if (hd_ok) begin
                    ctl_d.retire = 1'b1;
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase

        if (ctl_d.retire) begin
            buf_pop         = 1'b1;
            ctl_d.retire_pc = hd_pc;
            ctl_d.nxt_pc    = hd_pc + PC_W'(INSN_BYTES);
            if (hd_rfi) begin
                ctl_d.ee = ctl_q.saved_ee;
            end
        end

        if (ctl_d.take) begin
            buf_clr        = 1'b1;
            ctl_d.saved_ee = ctl_q.ee;
            ctl_d.ee       = 1'b0;
            ctl_d.st       = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_RUN;
            ctl_q.ee        <= 1'b1;
            ctl_q.saved_ee  <= 1'b1;
            ctl_q.nxt_pc    <= RESET_PC;
            ctl_q.retire    <= 1'b0;
            ctl_q.retire_pc <= '0;
            ctl_q.take      <= 1'b0;
            ctl_q.take_exc  <= 1'b0;
            ctl_q.epc       <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign issue_stall_o = (ctl_q.st == ST_DRAIN);
    assign retire_o      = ctl_q.retire;
    assign retire_pc_o   = ctl_q.retire_pc;
    assign take_o        = ctl_q.take;
    assign take_exc_o    = ctl_q.take_exc;
    assign epc_o         = ctl_q.epc;
    assign flush_o       = ctl_q.take;
    assign msr_ee_o      = ctl_q.ee;

endmodule

// File: rtl/irq_ret_ctrl_chk.sv
module irq_ret_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_irq_req_i,
    input logic issue_stall_o,
    input logic retire_o,
    input logic take_o,
    input logic take_exc_o,
    input logic msr_ee_o
);

    // R7
    take_clears_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !msr_ee_o);

    // R7
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R2
    retire_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_o && take_o));

    // R3
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_stall_o) |-> $past(ext_irq_req_i && msr_ee_o));

    // R11
    masked_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_ee_o && !issue_stall_o) |=> !issue_stall_o);

    // R5
    ext_take_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_exc_o) |-> $past(issue_stall_o));

endmodule

bind irq_ret_ctrl irq_ret_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_irq_req_i (ext_irq_req_i),
    .issue_stall_o (issue_stall_o),
    .retire_o      (retire_o),
    .take_o        (take_o),
    .take_exc_o    (take_exc_o),
    .msr_ee_o      (msr_ee_o)
);

// File: tb/tb_irq_ret_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ret_ctrl;

    localparam int DEPTH = 4;
    localparam int PC_W  = 32;
    localparam int IDX_W = 2;

    localparam logic [2:0] C_ALU = 3'd0, C_RFI = 3'd3, C_MEM = 3'd4, C_CACHE = 3'd5;
    localparam int K_RET = 0, K_EXT = 1, K_EXC = 2;

    typedef struct {
        int              kind;
        logic [PC_W-1:0] pc;
        string           req;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid_i = 1'b0;
    logic [PC_W-1:0]  alloc_pc_i = '0;
    logic [2:0]       alloc_cls_i = '0;
    logic [IDX_W-1:0] alloc_tag_o;
    logic             buf_full_o;
    logic             cmpl_valid_i = 1'b0;
    logic [IDX_W-1:0] cmpl_tag_i = '0;
    logic             cmpl_exc_i = 1'b0;
    logic             ext_irq_req_i = 1'b0;
    logic             issue_stall_o, retire_o, take_o, take_exc_o, flush_o, msr_ee_o;
    logic [PC_W-1:0]  retire_pc_o, epc_o;

    int  checks = 0;
    int  failures = 0;
    bit  done_flag = 0;
    ev_t expq[$];

    always #2.5 clk = ~clk;

    irq_ret_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W), .INSN_BYTES(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_pc_i(alloc_pc_i), .alloc_cls_i(alloc_cls_i),
        .alloc_tag_o(alloc_tag_o), .buf_full_o(buf_full_o),
        .cmpl_valid_i(cmpl_valid_i), .cmpl_tag_i(cmpl_tag_i), .cmpl_exc_i(cmpl_exc_i),
        .ext_irq_req_i(ext_irq_req_i), .issue_stall_o(issue_stall_o),
        .retire_o(retire_o), .retire_pc_o(retire_pc_o),
        .take_o(take_o), .take_exc_o(take_exc_o), .epc_o(epc_o),
        .flush_o(flush_o), .msr_ee_o(msr_ee_o)
    );

    task automatic check(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [PC_W-1:0] pc, input string req);
        ev_t e;
        e.kind = kind; e.pc = pc; e.req = req;
        expq.push_back(e);
    endtask

    task automatic do_alloc(input logic [PC_W-1:0] pc, input logic [2:0] cls,
                            output logic [IDX_W-1:0] tag);
        alloc_valid_i = 1'b1; alloc_pc_i = pc; alloc_cls_i = cls;
        tag = alloc_tag_o;
        @(negedge clk);
        alloc_valid_i = 1'b0;
    endtask

    task automatic do_cmpl(input logic [IDX_W-1:0] tag, input logic exc);
        cmpl_valid_i = 1'b1; cmpl_tag_i = tag; cmpl_exc_i = exc;
        @(negedge clk);
        cmpl_valid_i = 1'b0; cmpl_exc_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected events as the design reports them
    always @(negedge clk) begin
        if (rst_n && (retire_o || take_o)) begin
            int   act_kind;
            ev_t  e;
            act_kind = retire_o ? K_RET : (take_exc_o ? K_EXC : K_EXT);
            checks++;
            if (expq.size() == 0) begin
                failures++;
                $display("FAIL unexpected event actual kind=%0d pc=%0h expected none",
                         act_kind, retire_o ? retire_pc_o : epc_o);
            end else begin
                e = expq.pop_front();
                if (act_kind != e.kind ||
                    (retire_o ? retire_pc_o : epc_o) !== e.pc ||
                    (take_o && flush_o !== 1'b1)) begin
                    failures++;
                    $display("FAIL %s actual kind=%0d pc=%0h expected kind=%0d pc=%0h",
                             e.req, act_kind, retire_o ? retire_pc_o : epc_o, e.kind, e.pc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] t0, t1, t2, t3, tx;
        idle(3);
        // R1 reset state
        check("R1 ee", msr_ee_o, 1);
        check("R1 stall", issue_stall_o, 0);
        check("R1 full", buf_full_o, 0);
        check("R1 pulses", {retire_o, take_o}, 0);
        rst_n = 1'b1;
        idle(2);

        // R2 normal in-order retirement
        do_alloc(32'h200, C_ALU, t0);
        do_alloc(32'h204, C_ALU, t1);
        do_alloc(32'h208, C_ALU, t2);
        expect_ev(K_RET, 32'h200, "R2");
        expect_ev(K_RET, 32'h204, "R2");
        expect_ev(K_RET, 32'h208, "R2");
        do_cmpl(t0, 0); do_cmpl(t1, 0); do_cmpl(t2, 0);
        idle(4);

        // R3 R4 R6 drain of allowed classes, waiting on unfinished memory op
        do_alloc(32'h300, C_MEM, t0);
        do_alloc(32'h304, C_CACHE, t1);
        ext_irq_req_i = 1'b1;
        idle(1);
        check("R3 stall raised", issue_stall_o, 1);
        do_alloc(32'h3F0, C_ALU, tx);          // dropped during stall (R3)
        idle(3);
        check("R4 waits", issue_stall_o, 1);
        expect_ev(K_RET, 32'h300, "R4");
        expect_ev(K_RET, 32'h304, "R4");
        expect_ev(K_EXT, 32'h308, "R6");
        do_cmpl(t0, 0); do_cmpl(t1, 0);
        idle(4);
        ext_irq_req_i = 1'b0;
        check("R7 ee cleared", msr_ee_o, 0);

        // R11 masked request ignored
        ext_irq_req_i = 1'b1;
        do_alloc(32'h400, C_ALU, t0);
        expect_ev(K_RET, 32'h400, "R11");
        do_cmpl(t0, 0);
        idle(3);
        check("R11 no stall", issue_stall_o, 0);

        // R10 rfi restores enable, request seen one cycle later
        do_alloc(32'h404, C_RFI, t0);
        expect_ev(K_RET, 32'h404, "R10");
        expect_ev(K_EXT, 32'h408, "R10");
        do_cmpl(t0, 0);
        idle(1);
        check("R10 ee restored", msr_ee_o, 1);
        check("R10 no stall same cycle", issue_stall_o, 0);
        idle(1);
        check("R10 stall next cycle", issue_stall_o, 1);
        idle(3);
        ext_irq_req_i = 1'b0;
        do_alloc(32'h500, C_RFI, t0);
        expect_ev(K_RET, 32'h500, "R10");
        do_cmpl(t0, 0);
        idle(3);
        check("R10 ee re-enabled", msr_ee_o, 1);

        // R5 drain stops at disallowed class, flush
        do_alloc(32'h600, C_MEM, t0);
        do_alloc(32'h604, C_ALU, t1);
        do_alloc(32'h608, C_MEM, t2);
        ext_irq_req_i = 1'b1;
        idle(1);
        expect_ev(K_RET, 32'h600, "R4");
        expect_ev(K_EXT, 32'h604, "R5");
        do_cmpl(t1, 0);
        do_cmpl(t0, 0);
        idle(4);
        ext_irq_req_i = 1'b0;
        check("R5 flushed not full", buf_full_o, 0);
        do_alloc(32'h650, C_ALU, t0);          // would be blocked by 0x608 if not flushed
        expect_ev(K_RET, 32'h650, "R5 flush");
        do_cmpl(t0, 0);
        idle(3);
        do_alloc(32'h660, C_RFI, t0);
        expect_ev(K_RET, 32'h660, "R10");
        do_cmpl(t0, 0);
        idle(3);

        // R8 fault wins over external request in same cycle
        do_alloc(32'h700, C_MEM, t0);
        do_alloc(32'h704, C_ALU, t1);
        expect_ev(K_EXC, 32'h700, "R8");
        ext_irq_req_i = 1'b1;
        do_cmpl(t0, 1);
        idle(4);
        ext_irq_req_i = 1'b0;
        check("R7 ee cleared by fault take", msr_ee_o, 0);

        // R9 only oldest fault is taken
        do_alloc(32'h800, C_ALU, t0);
        do_alloc(32'h804, C_ALU, t1);
        do_cmpl(t1, 1);
        idle(2);
        expect_ev(K_EXC, 32'h800, "R9");
        do_cmpl(t0, 1);
        idle(4);

        // R12 allocation dropped when full
        do_alloc(32'h900, C_ALU, t0);
        do_alloc(32'h904, C_ALU, t1);
        do_alloc(32'h908, C_ALU, t2);
        do_alloc(32'h90C, C_ALU, t3);
        check("R12 full", buf_full_o, 1);
        do_alloc(32'h910, C_ALU, tx);
        expect_ev(K_RET, 32'h900, "R12");
        expect_ev(K_RET, 32'h904, "R12");
        expect_ev(K_RET, 32'h908, "R12");
        expect_ev(K_RET, 32'h90C, "R12");
        do_cmpl(t0, 0); do_cmpl(t1, 0); do_cmpl(t2, 0); do_cmpl(t3, 0);
        idle(4);
        check("R12 empty after drain", buf_full_o, 0);
        do_alloc(32'h920, C_ALU, t0);
        expect_ev(K_RET, 32'h920, "R12");
        do_cmpl(t0, 0);
        idle(4);

        check("all expected events seen", expq.size(), 0);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule